// File: doc/BRIEF.md
# Polled Rotary Encoder Cutoff Index

This block turns detents of a two-phase rotary encoder into a small saturating index. A filter stage downstream uses the index to pick its cutoff setting. The encoder pins are first brought into the clock domain by a synchronizer. They are then looked at only on a slow poll. The poll fires on every 64th pulse of the audio sample strobe, which at usual audio rates is a spacing of about one and a half milliseconds. The spacing is slow enough that contact bounce on the encoder is not seen.

A two-state detent machine handles the edges. It moves from ARMED to LATCHED when a poll finds phase 0 low. On that transition it emits one step, whose direction is set by phase 1: up when phase 1 is high, down when it is low. The machine goes back from LATCHED to ARMED only when a poll finds phase 0 high again. In every other case it holds its state (ARMED on phase 0 high, LATCHED on phase 0 low).

The index register applies each step, saturating at 0 and 6. It raises a one-clock change pulse only when the index really moved. The filter uses that pulse to clear its history.

Top module: `enc_cutoff_ctrl`

## Requirements
- R1: After reset the index is 3 and the change pulse is low.
- R2: The encoder is examined only on every 64th sample strobe counted from reset. Strobes in between, and encoder activity between polls, leave the index and the pulse unchanged.
- R3: A poll that sees phase 0 high re-arms the detent machine and leaves the index unchanged.
- R4: A poll that sees phase 0 low while armed, with phase 1 high, raises the index by one.
- R5: A poll that sees phase 0 low while armed, with phase 1 low, lowers the index by one.
- R6: A poll that sees phase 0 low while already latched has no effect. Only one step is taken per low period of phase 0.
- R7: A step up when the index is 6 leaves it at 6 and raises no pulse.
- R8: A step down when the index is 0 leaves it at 0 and raises no pulse.
- R9: Every change of the index is marked by the change pulse. The pulse is high for exactly one clock, in the clock after the poll strobe, together with the new index.
- R10: The encoder inputs pass through a two-flop synchronizer. A value presented one clock before the poll strobe is not seen by that poll. A value held for two clocks or more before the poll strobe is seen by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | Audio sample strobe, one clock per sample |
| enc_ph0 | input | 1 | Encoder phase 0, asynchronous |
| enc_ph1 | input | 1 | Encoder phase 1, asynchronous |
| cut_idx | output | 3 | Saturating cutoff index, 0 to 6 |
| idx_chg | output | 1 | One-clock pulse when the index changes |

## Verification
The assertions assume that the sample strobe is never high for two clocks in a row. This keeps consecutive polls far apart, so a change pulse is never directly followed by another. The assertions also assume that reset is applied from time zero. The stimulus drives the strobe as isolated one-clock pulses with random gaps. It holds the encoder levels for several clocks before each poll, except in the one case where a late change is made on purpose to exercise the synchronizer delay. Random levels between polls exercise the rule that only polls are observed.

// File: rtl/enc_pkg.sv
package enc_pkg;

    typedef enum logic {
        ST_ARMED   = 1'b0,
        ST_LATCHED = 1'b1
    } det_state_t;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_t;

endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
    parameter int W       = 2,
    parameter int STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= RST_VAL;
            else     stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/enc_poll_div.sv
module enc_poll_div #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    output logic poll
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign poll = stb && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (poll) cnt <= '0;
        else if (stb)  cnt <= cnt + 1'b1;
    end

    p_poll_on_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        poll |-> stb);

    p_no_back_to_back_poll_r2: assert property (@(posedge clk) disable iff (rst)
        poll |=> !poll);

endmodule

// File: rtl/enc_detent_fsm.sv
module enc_detent_fsm
    import enc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  poll,
    input  logic  ph0,
    input  logic  ph1,
    output step_t step
);

    det_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_ARMED;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        step     = STEP_NONE;
        if (poll) begin
            unique case (state)
                ST_ARMED: begin
                    if (!ph0) begin
                        state_nx = ST_LATCHED;
                        step     = ph1 ? STEP_UP : STEP_DN;
                    end
                end
                ST_LATCHED: begin
                    if (ph0) state_nx = ST_ARMED;
                end
                default: state_nx = ST_ARMED;
            endcase
        end
    end

    p_step_needs_low_poll_r4: assert property (@(posedge clk) disable iff (rst)
        (step != STEP_NONE) |-> (poll && !ph0));

    p_latched_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LATCHED) |-> (step == STEP_NONE));

    p_high_rearms_r3: assert property (@(posedge clk) disable iff (rst)
        (poll && ph0) |=> (state == ST_ARMED));

endmodule

// File: rtl/enc_index_reg.sv
module enc_index_reg
    import enc_pkg::*;
#(
    parameter int W    = 3,
    parameter int MAXV = 6,
    parameter int INIT = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  step_t        step,
    output logic [W-1:0] idx,
    output logic         chg
);

    localparam logic [W-1:0] TOP  = W'(MAXV);
    localparam logic [W-1:0] BOOT = W'(INIT);

    logic [W-1:0] idx_nx;
    logic         chg_nx;

    always_comb begin
        idx_nx = idx;
        chg_nx = 1'b0;
        unique case (step)
            STEP_UP: if (idx < TOP) begin
                idx_nx = idx + 1'b1;
                chg_nx = 1'b1;
            end
            STEP_DN: if (idx != '0) begin
                idx_nx = idx - 1'b1;
                chg_nx = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= BOOT;
            chg <= 1'b0;
        end else begin
            idx <= idx_nx;
            chg <= chg_nx;
        end
    end

    p_idx_in_range_r7: assert property (@(posedge clk) disable iff (rst)
        idx <= TOP);

    p_chg_marks_move_r9: assert property (@(posedge clk) disable iff (rst)
        chg == (idx != $past(idx)));

    p_chg_one_clock_r9: assert property (@(posedge clk) disable iff (rst)
        chg |=> !chg);

    p_unit_move_r4: assert property (@(posedge clk) disable iff (rst)
        (idx != $past(idx)) |-> ((idx == $past(idx) + 1'b1) || (idx == $past(idx) - 1'b1)));

    p_quiet_without_step_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(step) == STEP_NONE) |-> $stable(idx));

endmodule

// File: rtl/enc_cutoff_ctrl.sv
module enc_cutoff_ctrl
    import enc_pkg::*;
#(
    parameter int POLL_DIV    = 64,
    parameter int SYNC_STAGES = 2,
    parameter int IDX_W       = 3,
    parameter int IDX_MAX     = 6,
    parameter int IDX_INIT    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_stb,
    input  logic             enc_ph0,
    input  logic             enc_ph1,
    output logic [IDX_W-1:0] cut_idx,
    output logic             idx_chg
);

    logic [1:0] pins_s;
    logic       poll;
    step_t      step;

    enc_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({enc_ph1, enc_ph0}),
        .dout (pins_s)
    );

    enc_poll_div #(.DIV(POLL_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .stb  (smp_stb),
        .poll (poll)
    );

    enc_detent_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .poll (poll),
        .ph0  (pins_s[0]),
        .ph1  (pins_s[1]),
        .step (step)
    );

    enc_index_reg #(.W(IDX_W), .MAXV(IDX_MAX), .INIT(IDX_INIT)) u_idx (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .idx  (cut_idx),
        .chg  (idx_chg)
    );

    p_pulse_follows_poll_r9: assert property (@(posedge clk) disable iff (rst)
        idx_chg |-> $past(poll));

endmodule

// File: tb/sim_enc_cutoff_ctrl.sv
module sim_enc_cutoff_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_stb = 1'b0;
    logic       enc_ph0 = 1'b1;
    logic       enc_ph1 = 1'b1;
    logic [2:0] cut_idx;
    logic       idx_chg;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done   = 1'b0;

    int  m_idx   = 3;
    bit  m_armed = 1'b1;

    always #5 clk = ~clk;

    enc_cutoff_ctrl u0 (
        .clk     (clk),
        .rst     (rst),
        .smp_stb (smp_stb),
        .enc_ph0 (enc_ph0),
        .enc_ph1 (enc_ph1),
        .cut_idx (cut_idx),
        .idx_chg (idx_chg)
    );

    always @(posedge clk) if (!rst && idx_chg) pulses++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // bench model of one poll; returns whether the index moves
    function automatic bit model_poll(input bit a, input bit b);
        bit moved = 1'b0;
        if (a) m_armed = 1'b1;
        else if (m_armed) begin
            m_armed = 1'b0;
            if (b && m_idx < 6)       begin m_idx++; moved = 1'b1; end
            else if (!b && m_idx > 0) begin m_idx--; moved = 1'b1; end
        end
        return moved;
    endfunction

    task automatic one_strobe();
        @(negedge clk) smp_stb = 1'b1;
        @(negedge clk) smp_stb = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
    endtask

    task automatic do_poll(input bit a, input bit b, input bit late, input string req);
        bit moved;
        pulses = 0;
        for (int i = 0; i < 63; i++) begin
            enc_ph0 = 1'($urandom);
            enc_ph1 = 1'($urandom);
            one_strobe();
        end
        @(negedge clk);
        chk("R2 no pulse before poll", pulses, 0);
        chk("R2 index held before poll", int'(cut_idx), m_idx);
        enc_ph0 = a;
        enc_ph1 = b;
        repeat (3) @(negedge clk);
        if (late) begin
            enc_ph0 = !a;
            enc_ph1 = !b;
            @(negedge clk);
        end
        smp_stb = 1'b1;
        moved = model_poll(a, b);
        @(negedge clk) smp_stb = 1'b0;
        chk({req, " index"}, int'(cut_idx), m_idx);
        chk({req, " R9 pulse"}, int'(idx_chg), int'(moved));
        @(negedge clk);
        chk("R9 pulse one clock", int'(idx_chg), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset index", int'(cut_idx), 3);
        chk("R1 reset pulse", int'(idx_chg), 0);

        do_poll(1, 0, 0, "R3 rearm");
        do_poll(0, 1, 0, "R4 up");
        do_poll(0, 1, 0, "R6 latched");
        do_poll(0, 0, 0, "R6 latched down");
        do_poll(1, 1, 0, "R3 rearm");
        do_poll(0, 1, 0, "R4 up");
        do_poll(1, 1, 0, "R3 rearm");
        do_poll(0, 1, 0, "R4 up to top");
        do_poll(1, 1, 0, "R3 rearm");
        do_poll(0, 1, 0, "R7 top saturation");
        for (int k = 0; k < 7; k++) begin
            do_poll(1, 0, 0, "R3 rearm");
            do_poll(0, 0, 0, "R5 down");
        end
        do_poll(1, 0, 0, "R3 rearm");
        do_poll(0, 0, 0, "R8 bottom saturation");
        do_poll(1, 0, 0, "R3 rearm");
        // late flip to (1,0): synchronizer must still deliver (0,1)
        do_poll(0, 1, 1, "R10 late change ignored");
        do_poll(1, 1, 0, "R3 rearm");
        for (int k = 0; k < 40; k++)
            do_poll(1'($urandom), 1'($urandom), 0, "R4 R5 random");
        done = 1'b1;
    end

    initial begin
        void'($urandom(32'd1234));
        fork
            begin
                wait (done);
            end
            begin
                repeat (190000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule